// File: doc/BRIEF.md
# Paired Row-Column Command Arbiter

This block makes the final dispatch decision of a memory controller. Each controller cycle it looks at the entries of a command scoreboard, each of which may be ready to issue a row command (activate or precharge) and/or a column command (read or write). It picks winners only from entries that are flagged ready and that the timing enables permit. It drives the result, registered, onto the memory command bus together with a one-hot grant per slot and an issue strobe back to the scoreboard.

In normal mode one command leaves per controller cycle. In quasi-1T mode the controller runs at half rate, and each controller cycle carries two memory-clock slots. The arbiter then fills a row slot and a column slot in the same cycle, taking the two commands from different entries. Age values supplied with the entries set the order among candidates of the same type. The timing rules themselves are evaluated elsewhere and arrive as three enable inputs.

Top module: `paired_cmd_arbiter`

## Requirements
- R1: While `rst_n` is low, `row_cmd` and `col_cmd` are 0 (NOP), both grant vectors are 0 and `issue` is 0.
- R2: Entry i is a row candidate only when `row_rdy[i]` is 1. When `row_is_act[i]` is 1 the command is an activate (row code 1) and also needs `act_ok`. When `row_is_act[i]` is 0 it is a precharge (row code 2), and `act_ok` does not gate it.
- R3: Entry i is a column candidate only when `col_rdy[i]` is 1. A write (`col_is_wr[i]`=1, column code 2) also needs `wr_ok`, and a read (`col_is_wr[i]`=0, column code 1) also needs `rd_ok`.
- R4: With `quasi_en`=0 at most one slot is non-NOP per cycle. If any column candidate exists the column slot carries it and the row slot is NOP. Otherwise the row slot carries a row candidate, if there is one.
- R5: Within a slot the winner is the candidate with the smallest age value, where age i is `age_flat[i*AGE_W +: AGE_W]`. If ages are equal, the lower entry index wins.
- R6: With `quasi_en`=1, when a column candidate and a row candidate from another entry both exist, both slots are filled in the same cycle.
- R7: With `quasi_en`=1, a slot with no candidate of its type carries NOP (code 0) and a zero grant, while the other slot is still issued.
- R8: The two grants never name the same entry. In quasi mode the row slot takes the oldest row candidate that is not the column winner.
- R9: Outputs are registered. The decision for the inputs present before a rising clock edge is visible right after that edge. Each grant vector is one-hot for a non-NOP slot and zero for a NOP slot. `issue` is 1 exactly when at least one slot is non-NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quasi_en | input | 1 | 1 selects paired (quasi-1T) issue |
| act_ok | input | 1 | Activate timing window open |
| rd_ok | input | 1 | Read timing window open |
| wr_ok | input | 1 | Write timing window open |
| row_rdy | input | N_ENT | Per-entry row command ready |
| row_is_act | input | N_ENT | Per-entry row type: 1 activate, 0 precharge |
| col_rdy | input | N_ENT | Per-entry column command ready |
| col_is_wr | input | N_ENT | Per-entry column type: 1 write, 0 read |
| age_flat | input | N_ENT*AGE_W | Packed per-entry age, smaller is older |
| row_cmd | output | 2 | Row slot: 0 NOP, 1 ACT, 2 PRE |
| row_gnt | output | N_ENT | One-hot entry consumed by the row slot |
| col_cmd | output | 2 | Column slot: 0 NOP, 1 RD, 2 WR |
| col_gnt | output | N_ENT | One-hot entry consumed by the column slot |
| issue | output | 1 | Strobe to the scoreboard: a command left this cycle |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge and computes the expected slots from those inputs with its own age search. It compares all five outputs on the next falling edge, so each comparison pairs one input set with the edge that registered it. Reset is checked while `rst_n` is still low, before the first registering edge.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ROW_NOP = 2'd0,
        ROW_ACT = 2'd1,
        ROW_PRE = 2'd2
    } row_op_e;

    typedef enum logic [1:0] {
        COL_NOP = 2'd0,
        COL_RD  = 2'd1,
        COL_WR  = 2'd2
    } col_op_e;

endpackage

// File: rtl/arb_cand_mask.sv
module arb_cand_mask #(
    parameter int N_ENT = 8
) (
    input  logic             act_ok,
    input  logic             rd_ok,
    input  logic             wr_ok,
    input  logic [N_ENT-1:0] row_rdy,
    input  logic [N_ENT-1:0] row_is_act,
    input  logic [N_ENT-1:0] col_rdy,
    input  logic [N_ENT-1:0] col_is_wr,
    output logic [N_ENT-1:0] row_cand,
    output logic [N_ENT-1:0] col_cand
);

    // Per-entry gating by the timing windows; precharge is never held back.
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign row_cand[i] = row_rdy[i] && (!row_is_act[i] || act_ok);
        assign col_cand[i] = col_rdy[i] && (col_is_wr[i] ? wr_ok : rd_ok);
    end

endmodule

// File: rtl/arb_age_pick.sv
module arb_age_pick #(
    parameter int N_ENT = 8,
    parameter int AGE_W = 3
) (
    input  logic [N_ENT-1:0]       cand,
    input  logic [N_ENT*AGE_W-1:0] age_flat,
    output logic [N_ENT-1:0]       win_oh,
    output logic                   any
);

    logic [AGE_W-1:0] age_a [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_age
        assign age_a[i] = age_flat[i*AGE_W +: AGE_W];
    end

    // Entry i wins when it beats every other live candidate: strictly older,
    // or equally old with a lower index.
    for (genvar i = 0; i < N_ENT; i++) begin : g_win
        logic [N_ENT-1:0] beats;
        always_comb begin
            for (int j = 0; j < N_ENT; j++) begin
                if (j == i) begin
                    beats[j] = 1'b1;
                end else begin
                    beats[j] = !cand[j]
                             || (age_a[i] < age_a[j])
                             || ((age_a[i] == age_a[j]) && (i < j));
                end
            end
        end
        assign win_oh[i] = cand[i] && (&beats);
    end

    assign any = |cand;

endmodule

// File: rtl/paired_cmd_arbiter.sv
module paired_cmd_arbiter
    import arb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int AGE_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   quasi_en,
    input  logic                   act_ok,
    input  logic                   rd_ok,
    input  logic                   wr_ok,
    input  logic [N_ENT-1:0]       row_rdy,
    input  logic [N_ENT-1:0]       row_is_act,
    input  logic [N_ENT-1:0]       col_rdy,
    input  logic [N_ENT-1:0]       col_is_wr,
    input  logic [N_ENT*AGE_W-1:0] age_flat,
    output logic [1:0]             row_cmd,
    output logic [N_ENT-1:0]       row_gnt,
    output logic [1:0]             col_cmd,
    output logic [N_ENT-1:0]       col_gnt,
    output logic                   issue
);

    typedef struct packed {
        row_op_e          row_op;
        logic [N_ENT-1:0] row_gnt;
        col_op_e          col_op;
        logic [N_ENT-1:0] col_gnt;
        logic             issue;
    } slot_s;

    logic [N_ENT-1:0] row_cand, col_cand, row_pool;
    logic [N_ENT-1:0] row_win, col_win;
    logic             row_any, col_any;
    slot_s            slot_d, slot_q;

    arb_cand_mask #(.N_ENT(N_ENT)) mask_i (
        .act_ok     (act_ok),
        .rd_ok      (rd_ok),
        .wr_ok      (wr_ok),
        .row_rdy    (row_rdy),
        .row_is_act (row_is_act),
        .col_rdy    (col_rdy),
        .col_is_wr  (col_is_wr),
        .row_cand   (row_cand),
        .col_cand   (col_cand)
    );

    arb_age_pick #(.N_ENT(N_ENT), .AGE_W(AGE_W)) col_pick_i (
        .cand     (col_cand),
        .age_flat (age_flat),
        .win_oh   (col_win),
        .any      (col_any)
    );

    // The column winner is removed from the row pool so a pair never shares an entry.
    assign row_pool = row_cand & ~col_win;

    arb_age_pick #(.N_ENT(N_ENT), .AGE_W(AGE_W)) row_pick_i (
        .cand     (row_pool),
        .age_flat (age_flat),
        .win_oh   (row_win),
        .any      (row_any)
    );

    always_comb begin
        slot_d.row_op  = ROW_NOP;
        slot_d.row_gnt = '0;
        slot_d.col_op  = COL_NOP;
        slot_d.col_gnt = '0;
        if (col_any) begin
            slot_d.col_op  = (|(col_win & col_is_wr)) ? COL_WR : COL_RD;
            slot_d.col_gnt = col_win;
        end
        if (row_any && (quasi_en || !col_any)) begin
            slot_d.row_op  = (|(row_win & row_is_act)) ? ROW_ACT : ROW_PRE;
            slot_d.row_gnt = row_win;
        end
        slot_d.issue = (slot_d.row_op != ROW_NOP) || (slot_d.col_op != COL_NOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign row_cmd = slot_q.row_op;
    assign row_gnt = slot_q.row_gnt;
    assign col_cmd = slot_q.col_op;
    assign col_gnt = slot_q.col_gnt;
    assign issue   = slot_q.issue;

    AST_COL_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_gnt)); // R9
    AST_ROW_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_gnt)); // R9
    AST_NO_SHARED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (row_gnt & col_gnt) == '0); // R8
    AST_COL_GNT_WAS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (col_gnt & ~$past(col_cand)) == '0); // R3
    AST_ROW_GNT_WAS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (row_gnt & ~$past(row_cand)) == '0); // R2
    AST_COL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (|col_cand) |=> col_cmd != 2'd0); // R4
    AST_NORMAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !quasi_en |=> (row_cmd == 2'd0) || (col_cmd == 2'd0)); // R4

endmodule

// File: tb/paired_cmd_arbiter_tb_top.sv
module paired_cmd_arbiter_tb_top;

    localparam int N  = 8;
    localparam int AW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            quasi_en = 1'b0, act_ok = 1'b0, rd_ok = 1'b0, wr_ok = 1'b0;
    logic [N-1:0]    row_rdy = '0, row_is_act = '0, col_rdy = '0, col_is_wr = '0;
    logic [N*AW-1:0] age_flat = '0;
    logic [1:0]      row_cmd, col_cmd;
    logic [N-1:0]    row_gnt, col_gnt;
    logic            issue;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    int e_rcmd, e_ccmd;
    logic [N-1:0] e_rgnt, e_cgnt;
    logic e_issue;

    always #2 clk = ~clk;

    paired_cmd_arbiter #(.N_ENT(N), .AGE_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .quasi_en(quasi_en), .act_ok(act_ok),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .row_rdy(row_rdy), .row_is_act(row_is_act),
        .col_rdy(col_rdy), .col_is_wr(col_is_wr), .age_flat(age_flat),
        .row_cmd(row_cmd), .row_gnt(row_gnt), .col_cmd(col_cmd),
        .col_gnt(col_gnt), .issue(issue)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int age_of(input int i);
        return int'(age_flat[i*AW +: AW]);
    endfunction

    // Oldest candidate in c, skipping entry ex; -1 if none.
    function automatic int oldest(input logic [N-1:0] c, input int ex);
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (c[i] && i != ex) begin
                if (best < 0 || age_of(i) < age_of(best)) best = i;
            end
        end
        return best;
    endfunction

    task automatic model();
        logic [N-1:0] rc, cc;
        int c, r;
        for (int i = 0; i < N; i++) begin
            rc[i] = row_rdy[i] && (!row_is_act[i] || act_ok);
            cc[i] = col_rdy[i] && (col_is_wr[i] ? wr_ok : rd_ok);
        end
        c = oldest(cc, -1);
        r = oldest(rc, c);
        if (!quasi_en && c >= 0) r = -1;
        e_ccmd = (c < 0) ? 0 : (col_is_wr[c] ? 2 : 1);
        e_cgnt = (c < 0) ? '0 : (N'(1) << c);
        e_rcmd = (r < 0) ? 0 : (row_is_act[r] ? 1 : 2);
        e_rgnt = (r < 0) ? '0 : (N'(1) << r);
        e_issue = (c >= 0) || (r >= 0);
    endtask

    // Inputs are stable here (set on a falling edge); result is due after the next rising edge.
    task automatic cycle();
        model();
        @(posedge clk);
        @(negedge clk);
        chk("col_cmd", int'(col_cmd), e_ccmd);
        chk("col_gnt", int'(col_gnt), int'(e_cgnt));
        chk("row_cmd", int'(row_cmd), e_rcmd);
        chk("row_gnt", int'(row_gnt), int'(e_rgnt));
        chk("issue", int'(issue), int'(e_issue));
    endtask

    task automatic set_age(input int i, input int v);
        age_flat[i*AW +: AW] = AW'(v);
    endtask

    task automatic clear_all();
        row_rdy = '0; row_is_act = '0; col_rdy = '0; col_is_wr = '0;
        act_ok = 1'b1; rd_ok = 1'b1; wr_ok = 1'b1;
        for (int i = 0; i < N; i++) set_age(i, N - 1 - i);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=<50000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset holds NOP even with every entry ready.
        tag = "R1";
        clear_all();
        row_rdy = '1; col_rdy = '1; quasi_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("row_cmd", int'(row_cmd), 0);
        chk("col_cmd", int'(col_cmd), 0);
        chk("row_gnt", int'(row_gnt), 0);
        chk("col_gnt", int'(col_gnt), 0);
        chk("issue", int'(issue), 0);
        rst_n = 1'b1;
        cycle();

        // R2: activate gated by act_ok, precharge not.
        tag = "R2";
        clear_all(); quasi_en = 1'b0;
        row_rdy = 8'b0000_0100; row_is_act = 8'b0000_0100; act_ok = 1'b0;
        cycle();
        row_rdy = 8'b0000_0110; row_is_act = 8'b0000_0100;
        cycle();
        act_ok = 1'b1;
        cycle();

        // R3: read and write windows mask column candidates.
        tag = "R3";
        clear_all();
        col_rdy = 8'b0011_0000; col_is_wr = 8'b0010_0000; rd_ok = 1'b0;
        cycle();
        rd_ok = 1'b1; wr_ok = 1'b0;
        cycle();
        rd_ok = 1'b0;
        cycle();

        // R4: normal mode prefers columns, one slot only.
        tag = "R4";
        clear_all(); quasi_en = 1'b0;
        row_rdy = 8'b1000_0000; row_is_act = 8'b1000_0000; col_rdy = 8'b0000_0001;
        cycle();
        col_rdy = '0;
        cycle();

        // R5: age order and equal-age index order.
        tag = "R5";
        clear_all();
        col_rdy = 8'b0101_0010;
        set_age(1, 5); set_age(4, 2); set_age(6, 3);
        cycle();
        set_age(6, 2);
        cycle();

        // R6: quasi mode fills both slots.
        tag = "R6";
        clear_all(); quasi_en = 1'b1;
        row_rdy = 8'b0000_1000; row_is_act = 8'b0000_1000;
        col_rdy = 8'b0100_0000; col_is_wr = 8'b0100_0000;
        cycle();

        // R7: quasi mode with a single type ready.
        tag = "R7";
        col_rdy = '0;
        cycle();
        col_rdy = 8'b0000_0010; row_rdy = '0;
        cycle();

        // R8: same entry oldest for both types.
        tag = "R8";
        clear_all(); quasi_en = 1'b1;
        row_rdy = 8'b0000_0011; col_rdy = 8'b0000_0001;
        set_age(0, 0); set_age(1, 4);
        cycle();
        row_rdy = 8'b0000_0001;
        cycle();

        // R9: random traffic, registered one-edge latency on every output.
        tag = "R9";
        for (int k = 0; k < 3000; k++) begin
            quasi_en   = 1'($urandom);
            act_ok     = 1'($urandom);
            rd_ok      = 1'($urandom);
            wr_ok      = 1'($urandom);
            row_rdy    = N'($urandom) & N'($urandom);
            row_is_act = N'($urandom);
            col_rdy    = N'($urandom) & N'($urandom);
            col_is_wr  = N'($urandom);
            age_flat   = (N*AW)'($urandom);
            cycle();
        end

        finish_run();
    end

endmodule